// File: doc/BRIEF.md
# Console run and step controller

This block owns the run/halt state of a small sequential processor as seen from its front panel. Three keys (clear, load, start) pass through a synchroniser and an edge detector, so one press is one event however long the key is held. After CLEAR the machine may be started. A start with the bootstrap armed issues a one-cycle bootstrap pulse to the processor, which then reads an initial block of at most 129 words from the latched load unit. A start with the bootstrap not armed simply resumes the program.

While running, the block watches strobes from the processor: instruction end, microsequence end, timing-cycle end and the result of a jump test. Maintenance switches choose which of these stop the machine. The running program can inhibit step stops with an inhibit-step strobe. An enable-step strobe or CLEAR lifts the inhibit, and the override switch ignores it. A status-repeat switch holds back the loading of the next sequencer status.

Top module: `console_run_ctrl`

## Requirements
- R1: A CLEAR press stops the machine (run_o low), drops the bootstrap arm and the step inhibit, and enables later starts.
- R2: After reset, START presses are refused until CLEAR has been pressed once.
- R3: A START press while halted and cleared raises run_o on the third rising clock edge after start_i rises. A held START produces a single start.
- R4: A LOAD press while halted raises boot_arm_o and latches unit_sel_i into load_unit_o. The next accepted START drives boot_go_o high for exactly one cycle, while run_o is high, and clears boot_arm_o.
- R5: halt_lamp_o is high exactly when run_o is low. step_lamp_o is high when either step switch (sw_step_i or sw_ustep_i) is on.
- R6: While running, sw_step_i halts the machine at an instr_end_i strobe and sw_ustep_i halts it at a useq_end_i strobe. Each later START advances exactly one more step.
- R7: An inh_step_i strobe while running sets the step inhibit, and an ena_step_i strobe clears it. While the inhibit is set and sw_override_i is off, step halts do not occur. With sw_override_i on, step halts occur regardless of the inhibit.
- R8: With sw_cycstep_i on, each dl_end_i strobe halts the machine, whatever the step inhibit.
- R9: At a jump_eval_i strobe, sw_jtrue_i halts when jump_taken_i is 1, and sw_jfalse_i halts when jump_taken_i is 0. Without jump_eval_i no jump stop occurs.
- R10: status_load_en_o is high only while running with sw_repeat_i off.
- R11: Several halt causes in one cycle give one halt. run_o stays low until the next START press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| clear_i | input | 1 | CLEAR key, asynchronous level |
| load_i | input | 1 | LOAD key, asynchronous level |
| start_i | input | 1 | START key, asynchronous level |
| unit_sel_i | input | 1 | load unit select (0 or 1) |
| sw_step_i | input | 1 | stop at each instruction end |
| sw_ustep_i | input | 1 | stop at each microsequence end |
| sw_cycstep_i | input | 1 | stop at each timing-cycle end |
| sw_repeat_i | input | 1 | hold the next sequencer status |
| sw_override_i | input | 1 | step stops ignore the program inhibit |
| sw_jtrue_i | input | 1 | stop on a taken jump condition |
| sw_jfalse_i | input | 1 | stop on a not-taken jump condition |
| instr_end_i | input | 1 | processor strobe: instruction complete |
| useq_end_i | input | 1 | processor strobe: microsequence complete |
| dl_end_i | input | 1 | processor strobe: timing cycle complete |
| jump_eval_i | input | 1 | processor strobe: jump condition evaluated |
| jump_taken_i | input | 1 | jump condition result, valid with jump_eval_i |
| inh_step_i | input | 1 | processor strobe: inhibit-step instruction |
| ena_step_i | input | 1 | processor strobe: enable-step instruction |
| run_o | output | 1 | run enable to the processor |
| boot_arm_o | output | 1 | bootstrap armed |
| boot_go_o | output | 1 | one-cycle pulse: run starts as a bootstrap read |
| load_unit_o | output | 1 | latched load unit |
| halt_lamp_o | output | 1 | machine stopped |
| step_lamp_o | output | 1 | a step switch is on |
| status_load_en_o | output | 1 | next sequencer status may load |

## Verification
A key press takes effect on the third rising edge after the key rises: two synchroniser flops and then the state register. The bench holds each key for four cycles and samples on falling edges after that window. A processor strobe acts on the very next edge, so each strobe is driven for one cycle and run_o is sampled on the following falling edge. The one-cycle boot_go_o pulse is counted over the whole press window, so a missing pulse and a doubled pulse both show.

// File: rtl/csl_pkg.sv
package csl_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned N_KEYS          = 3;
  localparam int unsigned KEY_CLEAR       = 0;
  localparam int unsigned KEY_LOAD        = 1;
  localparam int unsigned KEY_START       = 2;

  typedef struct packed {
    logic step;
    logic ustep;
    logic cyc;
    logic override;
    logic jtrue;
    logic jfalse;
  } maint_sw_t;

  typedef struct packed {
    logic instr_end;
    logic useq_end;
    logic dl_end;
    logic jump_eval;
    logic jump_taken;
  } cpu_strb_t;
endpackage

// File: rtl/csl_key_edge.sv
module csl_key_edge #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned N      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] key_i,
  output logic [N-1:0] pls_o
);
  for (genvar k = 0; k < N; k++) begin : g_key
    logic [STAGES:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-1:0], key_i[k]};
    end
    // rising edge of the synchronised level
    assign pls_o[k] = sh_q[STAGES-1] & ~sh_q[STAGES];
  end
endmodule

// File: rtl/csl_halt_eval.sv
module csl_halt_eval
  import csl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic      clear_i,
  input  maint_sw_t sw_i,
  input  cpu_strb_t st_i,
  input  logic      inh_i,
  input  logic      ena_i,
  output logic      halt_o
);
  logic inhibit_q;
  logic step_ok, step_hit, cyc_hit, jmp_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                inhibit_q <= 1'b0;
    else if (clear_i)           inhibit_q <= 1'b0;
    else if (run_i && ena_i)    inhibit_q <= 1'b0;
    else if (run_i && inh_i)    inhibit_q <= 1'b1;
  end

  assign step_ok  = sw_i.override | ~inhibit_q;
  assign step_hit = step_ok & ((sw_i.step & st_i.instr_end) | (sw_i.ustep & st_i.useq_end));
  assign cyc_hit  = sw_i.cyc & st_i.dl_end;
  assign jmp_hit  = st_i.jump_eval &
                    ((sw_i.jtrue & st_i.jump_taken) | (sw_i.jfalse & ~st_i.jump_taken));
  assign halt_o   = run_i & (step_hit | cyc_hit | jmp_hit);
endmodule

// File: rtl/console_run_ctrl.sv
module console_run_ctrl
  import csl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic load_i,
  input  logic start_i,
  input  logic unit_sel_i,
  input  logic sw_step_i,
  input  logic sw_ustep_i,
  input  logic sw_cycstep_i,
  input  logic sw_repeat_i,
  input  logic sw_override_i,
  input  logic sw_jtrue_i,
  input  logic sw_jfalse_i,
  input  logic instr_end_i,
  input  logic useq_end_i,
  input  logic dl_end_i,
  input  logic jump_eval_i,
  input  logic jump_taken_i,
  input  logic inh_step_i,
  input  logic ena_step_i,
  output logic run_o,
  output logic boot_arm_o,
  output logic boot_go_o,
  output logic load_unit_o,
  output logic halt_lamp_o,
  output logic step_lamp_o,
  output logic status_load_en_o
);
  logic [N_KEYS-1:0] key_raw, key_pls;
  logic clear_pls, load_pls, start_pls;
  logic clr_seen_q, run_q, arm_q, unit_q, boot_go_q;
  logic halt, start_ok;
  maint_sw_t sw;
  cpu_strb_t st;

  assign key_raw[KEY_CLEAR] = clear_i;
  assign key_raw[KEY_LOAD]  = load_i;
  assign key_raw[KEY_START] = start_i;

  csl_key_edge #(.STAGES(SYNC_STAGES), .N(N_KEYS)) u_keys (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .key_i  (key_raw),
    .pls_o  (key_pls)
  );

  assign clear_pls = key_pls[KEY_CLEAR];
  assign load_pls  = key_pls[KEY_LOAD];
  assign start_pls = key_pls[KEY_START];

  assign sw = '{step: sw_step_i, ustep: sw_ustep_i, cyc: sw_cycstep_i,
                override: sw_override_i, jtrue: sw_jtrue_i, jfalse: sw_jfalse_i};
  assign st = '{instr_end: instr_end_i, useq_end: useq_end_i, dl_end: dl_end_i,
                jump_eval: jump_eval_i, jump_taken: jump_taken_i};

  csl_halt_eval u_halt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .clear_i (clear_pls),
    .sw_i    (sw),
    .st_i    (st),
    .inh_i   (inh_step_i),
    .ena_i   (ena_step_i),
    .halt_o  (halt)
  );

  assign start_ok = start_pls & clr_seen_q & ~run_q & ~clear_pls;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_seen_q <= 1'b0;
      run_q      <= 1'b0;
      arm_q      <= 1'b0;
      unit_q     <= 1'b0;
      boot_go_q  <= 1'b0;
    end else if (clear_pls) begin
      clr_seen_q <= 1'b1;
      run_q      <= 1'b0;
      arm_q      <= 1'b0;
      boot_go_q  <= 1'b0;
    end else begin
      boot_go_q <= 1'b0;
      if (load_pls && clr_seen_q && !run_q) begin
        arm_q  <= 1'b1;
        unit_q <= unit_sel_i;
      end
      if (halt) begin
        run_q <= 1'b0;
      end else if (start_ok) begin
        run_q     <= 1'b1;
        boot_go_q <= arm_q;
        arm_q     <= 1'b0;
      end
    end
  end

  assign run_o            = run_q;
  assign boot_arm_o       = arm_q;
  assign boot_go_o        = boot_go_q;
  assign load_unit_o      = unit_q;
  assign halt_lamp_o      = ~run_q;
  assign step_lamp_o      = sw_step_i | sw_ustep_i;
  assign status_load_en_o = run_q & ~sw_repeat_i;
endmodule

// File: rtl/console_run_ctrl_chk.sv
module console_run_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clear_pls,
  input logic start_pls,
  input logic clr_seen_q,
  input logic run_o,
  input logic boot_go_o,
  input logic boot_arm_o,
  input logic sw_cycstep_i,
  input logic sw_jtrue_i,
  input logic sw_jfalse_i,
  input logic sw_repeat_i,
  input logic dl_end_i,
  input logic jump_eval_i,
  input logic jump_taken_i,
  input logic status_load_en_o
);
  AST_CLEAR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_pls |=> !run_o); // R1
  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(start_pls) && $past(clr_seen_q) && !$past(clear_pls)); // R2
  AST_BOOT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_go_o |-> run_o && !boot_arm_o); // R4
  AST_BOOT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_go_o |=> !boot_go_o); // R4
  AST_CYC_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && sw_cycstep_i && dl_end_i |=> !run_o); // R8
  AST_JUMP_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && jump_eval_i && ((sw_jtrue_i && jump_taken_i) || (sw_jfalse_i && !jump_taken_i))
    |=> !run_o); // R9
  AST_REPEAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_repeat_i |-> !status_load_en_o); // R10
endmodule

bind console_run_ctrl console_run_ctrl_chk i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .clear_pls        (clear_pls),
  .start_pls        (start_pls),
  .clr_seen_q       (clr_seen_q),
  .run_o            (run_o),
  .boot_go_o        (boot_go_o),
  .boot_arm_o       (boot_arm_o),
  .sw_cycstep_i     (sw_cycstep_i),
  .sw_jtrue_i       (sw_jtrue_i),
  .sw_jfalse_i      (sw_jfalse_i),
  .sw_repeat_i      (sw_repeat_i),
  .dl_end_i         (dl_end_i),
  .jump_eval_i      (jump_eval_i),
  .jump_taken_i     (jump_taken_i),
  .status_load_en_o (status_load_en_o)
);

// File: tb/test_console_run_ctrl.sv
module test_console_run_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 0, load_i = 0, start_i = 0, unit_sel_i = 0;
  logic sw_step_i = 0, sw_ustep_i = 0, sw_cycstep_i = 0, sw_repeat_i = 0;
  logic sw_override_i = 0, sw_jtrue_i = 0, sw_jfalse_i = 0;
  logic instr_end_i = 0, useq_end_i = 0, dl_end_i = 0, jump_eval_i = 0, jump_taken_i = 0;
  logic inh_step_i = 0, ena_step_i = 0;
  logic run_o, boot_arm_o, boot_go_o, load_unit_o, halt_lamp_o, step_lamp_o, status_load_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  console_run_ctrl i_console_run_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .load_i(load_i), .start_i(start_i),
    .unit_sel_i(unit_sel_i), .sw_step_i(sw_step_i), .sw_ustep_i(sw_ustep_i),
    .sw_cycstep_i(sw_cycstep_i), .sw_repeat_i(sw_repeat_i), .sw_override_i(sw_override_i),
    .sw_jtrue_i(sw_jtrue_i), .sw_jfalse_i(sw_jfalse_i), .instr_end_i(instr_end_i),
    .useq_end_i(useq_end_i), .dl_end_i(dl_end_i), .jump_eval_i(jump_eval_i),
    .jump_taken_i(jump_taken_i), .inh_step_i(inh_step_i), .ena_step_i(ena_step_i),
    .run_o(run_o), .boot_arm_o(boot_arm_o), .boot_go_o(boot_go_o), .load_unit_o(load_unit_o),
    .halt_lamp_o(halt_lamp_o), .step_lamp_o(step_lamp_o), .status_load_en_o(status_load_en_o)
  );

  // sw = {jfalse,jtrue,override,repeat,cyc,ustep,step}; st = {jtaken,jeval,dl,useq,instr}
  typedef struct packed {
    logic [6:0] sw;
    logic [4:0] st;
    logic       er;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [14] = '{
    {7'b0000000, 5'b00001, 1'b1, 4'd3},
    {7'b0000001, 5'b00001, 1'b0, 4'd6},
    {7'b0000001, 5'b00010, 1'b1, 4'd6},
    {7'b0000010, 5'b00010, 1'b0, 4'd6},
    {7'b0000100, 5'b00100, 1'b0, 4'd8},
    {7'b0000100, 5'b00001, 1'b1, 4'd8},
    {7'b0100000, 5'b11000, 1'b0, 4'd9},
    {7'b0100000, 5'b01000, 1'b1, 4'd9},
    {7'b1000000, 5'b01000, 1'b0, 4'd9},
    {7'b1000000, 5'b11000, 1'b1, 4'd9},
    {7'b0100000, 5'b10000, 1'b1, 4'd9},
    {7'b0100101, 5'b11101, 1'b0, 4'd11},
    {7'b0001000, 5'b00000, 1'b1, 4'd10},
    {7'b0010000, 5'b00001, 1'b1, 4'd7}
  };

  task automatic chk(input logic act, input logic exp, input int req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic press(input int which);
    @(negedge clk);
    case (which) 0: clear_i = 1; 1: load_i = 1; default: start_i = 1; endcase
    repeat (4) @(negedge clk);
    clear_i = 0; load_i = 0; start_i = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_sw(input logic [6:0] s);
    @(negedge clk);
    {sw_jfalse_i, sw_jtrue_i, sw_override_i, sw_repeat_i, sw_cycstep_i, sw_ustep_i, sw_step_i} = s;
  endtask

  task automatic strobe(input logic [4:0] s);
    @(negedge clk);
    {jump_taken_i, jump_eval_i, dl_end_i, useq_end_i, instr_end_i} = s;
    @(negedge clk);
    {jump_taken_i, jump_eval_i, dl_end_i, useq_end_i, instr_end_i} = '0;
  endtask

  task automatic pulse_inh(input bit ena);
    @(negedge clk);
    if (ena) ena_step_i = 1; else inh_step_i = 1;
    @(negedge clk);
    ena_step_i = 0; inh_step_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int go_cnt;
    logic go_run;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // reset state, R5
    chk(run_o, 1'b0, 1, "reset run");
    chk(halt_lamp_o, 1'b1, 5, "reset halt lamp");
    chk(boot_arm_o, 1'b0, 4, "reset arm");
    chk(load_unit_o, 1'b0, 4, "reset unit");

    // R2: start refused before clear
    press(2);
    chk(run_o, 1'b0, 2, "start before clear");
    press(0);
    chk(run_o, 1'b0, 1, "after clear");

    // R3: start latency, third edge after start_i rises
    @(negedge clk); start_i = 1;
    @(negedge clk); chk(run_o, 1'b0, 3, "run after 1 edge");
    @(negedge clk); chk(run_o, 1'b0, 3, "run after 2 edges");
    @(negedge clk); chk(run_o, 1'b1, 3, "run after 3 edges");
    start_i = 0;
    press(0);
    chk(run_o, 1'b0, 1, "clear stops run");

    // vector table
    foreach (VEC[i]) begin
      set_sw(VEC[i].sw);
      press(2);
      chk(run_o, 1'b1, 3, "vector start");
      strobe(VEC[i].st);
      chk(run_o, VEC[i].er, VEC[i].req, "vector halt decision");
      chk(status_load_en_o, VEC[i].er & ~VEC[i].sw[3], 10, "status load enable");
      chk(step_lamp_o, VEC[i].sw[0] | VEC[i].sw[1], 5, "step lamp");
      chk(halt_lamp_o, ~VEC[i].er, 5, "halt lamp");
      if (VEC[i].req == 11) begin
        // R11: single halt, no restart without START
        repeat (5) begin
          @(negedge clk);
          chk(run_o, 1'b0, 11, "stays halted");
        end
      end
      press(0);
    end
    set_sw('0);

    // R3: held START gives one start; step halt while still held
    set_sw(7'b0000001);
    @(negedge clk); start_i = 1;
    repeat (4) @(negedge clk);
    chk(run_o, 1'b1, 3, "held start runs");
    strobe(5'b00001);
    repeat (10) @(negedge clk);
    chk(run_o, 1'b0, 3, "held start no second step");
    start_i = 0;
    repeat (3) @(negedge clk);
    // R6: next START advances one step
    press(2);
    chk(run_o, 1'b1, 6, "next step start");
    strobe(5'b00001);
    chk(run_o, 1'b0, 6, "next step halt");

    // R7: inhibit, enable, override, clear
    press(2);
    pulse_inh(0);
    strobe(5'b00001);
    chk(run_o, 1'b1, 7, "inhibited step no halt");
    pulse_inh(1);
    strobe(5'b00001);
    chk(run_o, 1'b0, 7, "enable restores step halt");
    press(2);
    pulse_inh(0);
    set_sw(7'b0010001);
    strobe(5'b00001);
    chk(run_o, 1'b0, 7, "override halts despite inhibit");
    set_sw(7'b0000001);
    press(2);
    pulse_inh(0);
    press(0);
    press(2);
    strobe(5'b00001);
    chk(run_o, 1'b0, 1, "clear lifts inhibit");

    // R8: cycle step ignores inhibit
    set_sw(7'b0000100);
    press(2);
    pulse_inh(0);
    strobe(5'b00100);
    chk(run_o, 1'b0, 8, "cycle step under inhibit");
    press(0);
    set_sw('0);

    // R4: load arms, latches unit, boot pulse once with run
    @(negedge clk); unit_sel_i = 1;
    press(1);
    unit_sel_i = 0;
    chk(boot_arm_o, 1'b1, 4, "arm after load");
    chk(load_unit_o, 1'b1, 4, "unit latched");
    go_cnt = 0; go_run = 0;
    @(negedge clk); start_i = 1;
    repeat (8) begin
      @(negedge clk);
      if (boot_go_o) begin go_cnt++; go_run = run_o; end
    end
    start_i = 0;
    chk(go_cnt == 1, 1'b1, 4, "single boot pulse");
    chk(go_run, 1'b1, 4, "boot pulse with run");
    chk(boot_arm_o, 1'b0, 4, "arm cleared after boot start");
    // R1: clear drops arm
    press(0);
    press(1);
    chk(boot_arm_o, 1'b1, 4, "rearm");
    press(0);
    chk(boot_arm_o, 1'b0, 1, "clear drops arm");
    finish_run();
  end
endmodule